// File: doc/BRIEF.md
# CAN Bootstrap Download Sequencer

This block runs a download session behind a CAN controller. Frames arrive and leave through an abstract frame interface. Each frame has a 29-bit identifier field, an extended-format flag, a length code and eight payload bytes, and each direction uses a valid/ready handshake. Byte 0 of a payload sits in bits 7:0 and byte 7 in bits 63:56. A 16-bit pair "bytes n+1..n" means byte n+1 is the high half.

After reset the sequencer watches for a start frame. The start frame names three values: the identifier to answer on, how many data frames will follow, and the identifier those data frames carry. The sequencer answers with one reply frame. The reply holds the bit-timing word supplied from outside and echoes the start-frame values, or carries a fixed error signature when the requested size does not fit the RAM window. In the data phase each matching frame is split into eight bytes. These bytes are written on consecutive cycles to increasing addresses from a fixed base. After the last frame the sequencer pulses a completion flag, shows the base address to jump to, and goes quiet.

Top module: `can_boot_seq`

## Requirements
- R1: After reset, rx_ready is 1 and tx_valid, wr_en, done and start_addr are all 0.
- R2: A start frame is recognised only when all of these hold: rx_ide = 0, rx_id = 0x555, rx_dlc = 8, byte 0 = 0x55 and byte 1 = 0x55. While the sequencer waits for a start frame, every other frame is consumed (rx_ready stays 1) and gives no reply.
- R3: The reply uses the start frame's word in bytes 3..2, called the reply word. tx_id equals the reply word's bits 12:0 with zero extension, tx_ide equals its bit 13, and tx_dlc is 8.
- R4: In the reply, bytes 1..0 hold the bit_timing input as sampled in the cycle the start frame is accepted, and bytes 3..2 echo the reply word.
- R5: On success, reply bytes 5..4 and 7..6 echo the start frame's bytes 5..4 and 7..6. On error, byte 4 = 0xDE, byte 5 = 0xAD, byte 6 = 0xBE and byte 7 = 0xEF.
- R6: The frame count is the start frame's bytes 5..4. The session is in error when the count is 0 or when count × 8 exceeds WIN_BYTES. With the defaults, 0x0800 is accepted and 0x0801 is refused.
- R7: tx_valid stays high, and the reply stays unchanged, until a cycle with tx_ready high. While the reply is pending, rx_ready is 0.
- R8: After an error reply, the sequencer waits for a new start frame and writes nothing. After a success reply, it enters the data phase.
- R9: In the data phase a frame is taken only when rx_dlc = 8, rx_ide equals bit 13 of the start frame's bytes 7..6, and rx_id equals bits 12:0 of that word. Any other frame is consumed with no write.
- R10: The bytes of an accepted frame are written byte 0 first, one per cycle on eight consecutive cycles. Addresses start at BASE_ADDR and rise by one for every byte of the session. rx_ready is 0 while a frame is being written out.
- R11: done is high for exactly one cycle, in the same cycle as the write of the final byte of the last counted frame. From then on start_addr equals BASE_ADDR, rx_ready stays 0 and no further writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received frame present |
| rx_ready | output | 1 | Sequencer takes the received frame |
| rx_id | input | 29 | Received identifier |
| rx_ide | input | 1 | Received frame uses extended format |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received payload, byte 0 in bits 7:0 |
| bit_timing | input | 16 | Measured bit-timing word |
| tx_valid | output | 1 | Reply frame present |
| tx_ready | input | 1 | Controller takes the reply frame |
| tx_id | output | 29 | Reply identifier |
| tx_ide | output | 1 | Reply uses extended format |
| tx_dlc | output | 4 | Reply length code |
| tx_data | output | 64 | Reply payload |
| wr_en | output | 1 | RAM byte write strobe |
| wr_addr | output | ADDR_W | RAM byte address |
| wr_data | output | 8 | RAM byte value |
| done | output | 1 | One-cycle completion pulse |
| start_addr | output | ADDR_W | Address to jump to after completion |

## Verification
Start-frame recognition is tried with a vector table. The table has one well-formed frame and then variants that each break a single field: the identifier, the format flag, the length code and the sync pattern. A failure therefore points to the one comparison that lets a wrong field through. The same table covers frame counts of zero, exactly the window, and one frame past the window. This separates an off-by-one in the size check from a missing zero check. It also includes a reply word with bit 13 set, to show that the extended flag is taken from the right bit.

The directed download mixes valid data frames with frames that have a neighbouring identifier, a short length and a flipped format flag. Checking the write stream byte by byte shows whether filtering, byte order, address continuity across frames and placement of the final pulse are each correct. Further directed cases cover a held-off reply, the return to waiting after an error reply, and quiet behaviour once the session is done.

// File: rtl/can_boot_pkg.sv
package can_boot_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_INIT,
    ST_SEND_ACK,
    ST_RECV,
    ST_PUMP,
    ST_HALT
  } seq_state_t;

  localparam logic [28:0] INIT_ID      = 29'h555;
  localparam logic [15:0] INIT_SYNC    = 16'h5555;
  localparam logic [3:0]  FULL_DLC     = 4'd8;
  localparam logic [15:0] ERR_SIG_LO   = 16'hADDE;
  localparam logic [15:0] ERR_SIG_HI   = 16'hEFBE;
  localparam int          FRAME_BYTES  = 8;

endpackage

// File: rtl/cbs_init_parse.sv
module cbs_init_parse
  import can_boot_pkg::*;
#(
  parameter int WIN_BYTES = 16384
) (
  input  logic [28:0] id,
  input  logic        ide,
  input  logic [3:0]  dlc,
  input  logic [63:0] data,
  output logic        is_init,
  output logic [15:0] reply_word,
  output logic [15:0] frame_count,
  output logic [15:0] data_word,
  output logic        count_bad
);

  localparam logic [16:0] MAX_FRAMES = 17'(WIN_BYTES / FRAME_BYTES);

  always_comb begin
    reply_word  = data[31:16];
    frame_count = data[47:32];
    data_word   = data[63:48];
    is_init     = !ide && (id == INIT_ID) && (dlc == FULL_DLC) &&
                  (data[15:0] == INIT_SYNC);
    count_bad   = (frame_count == 16'd0) || ({1'b0, frame_count} > MAX_FRAMES);
  end

endmodule

// File: rtl/cbs_ack_build.sv
module cbs_ack_build
  import can_boot_pkg::*;
(
  input  logic [15:0] reply_word,
  input  logic [15:0] frame_count,
  input  logic [15:0] data_word,
  input  logic [15:0] bit_timing,
  input  logic        err,
  output logic [28:0] ack_id,
  output logic        ack_ide,
  output logic [63:0] ack_data
);

  always_comb begin
    ack_id        = {16'd0, reply_word[12:0]};
    ack_ide       = reply_word[13];
    ack_data[15:0]  = bit_timing;
    ack_data[31:16] = reply_word;
    ack_data[47:32] = err ? ERR_SIG_LO : frame_count;
    ack_data[63:48] = err ? ERR_SIG_HI : data_word;
  end

endmodule

// File: rtl/cbs_byte_pump.sv
module cbs_byte_pump #(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1FFF_C000,
  parameter int              WIN_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [63:0]       frame_in,
  output logic              busy,
  output logic              emit_last,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  localparam int PTR_W = $clog2(WIN_BYTES) + 1;

  logic [63:0]      frame_q;
  logic [2:0]       idx_q;
  logic             active_q;
  logic [PTR_W-1:0] ptr_q;

  assign busy      = active_q;
  assign emit_last = active_q && (idx_q == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q  <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      ptr_q    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (active_q) begin
        wr_en   <= 1'b1;
        wr_addr <= BASE_ADDR + ADDR_W'(ptr_q);
        wr_data <= frame_q[{idx_q, 3'b000} +: 8];
        ptr_q   <= ptr_q + 1'b1;
        idx_q   <= idx_q + 1'b1;
        if (idx_q == 3'd7) active_q <= 1'b0;
      end else if (load) begin
        frame_q  <= frame_in;
        idx_q    <= '0;
        active_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/can_boot_seq.sv
module can_boot_seq
  import can_boot_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1FFF_C000,
  parameter int                WIN_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [28:0]       rx_id,
  input  logic              rx_ide,
  input  logic [3:0]        rx_dlc,
  input  logic [63:0]       rx_data,
  input  logic [15:0]       bit_timing,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [28:0]       tx_id,
  output logic              tx_ide,
  output logic [3:0]        tx_dlc,
  output logic [63:0]       tx_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic [ADDR_W-1:0] start_addr
);

  seq_state_t  state_q;
  logic        err_q;
  logic [15:0] frames_left_q;
  logic [13:0] data_id_q;

  logic        is_init;
  logic [15:0] reply_word, frame_count, data_word;
  logic        count_bad;
  logic [28:0] ack_id;
  logic        ack_ide;
  logic [63:0] ack_data;
  logic        pump_busy, pump_last, data_take;

  cbs_init_parse #(.WIN_BYTES(WIN_BYTES)) u_parse (
    .id(rx_id), .ide(rx_ide), .dlc(rx_dlc), .data(rx_data),
    .is_init(is_init), .reply_word(reply_word), .frame_count(frame_count),
    .data_word(data_word), .count_bad(count_bad)
  );

  cbs_ack_build u_ack (
    .reply_word(reply_word), .frame_count(frame_count), .data_word(data_word),
    .bit_timing(bit_timing), .err(count_bad),
    .ack_id(ack_id), .ack_ide(ack_ide), .ack_data(ack_data)
  );

  assign data_take = (state_q == ST_RECV) && rx_valid &&
                     (rx_dlc == FULL_DLC) && (rx_ide == data_id_q[13]) &&
                     (rx_id == {16'd0, data_id_q[12:0]});

  cbs_byte_pump #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES)) u_pump (
    .clk(clk), .rst(rst), .load(data_take), .frame_in(rx_data),
    .busy(pump_busy), .emit_last(pump_last),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign rx_ready = (state_q == ST_WAIT_INIT) || (state_q == ST_RECV);
  assign tx_valid = (state_q == ST_SEND_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_WAIT_INIT;
      err_q         <= 1'b0;
      frames_left_q <= '0;
      data_id_q     <= '0;
      tx_id         <= '0;
      tx_ide        <= 1'b0;
      tx_dlc        <= '0;
      tx_data       <= '0;
      done          <= 1'b0;
      start_addr    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_WAIT_INIT: begin
          if (rx_valid && is_init) begin
            tx_id         <= ack_id;
            tx_ide        <= ack_ide;
            tx_dlc        <= FULL_DLC;
            tx_data       <= ack_data;
            err_q         <= count_bad;
            frames_left_q <= frame_count;
            data_id_q     <= data_word[13:0];
            state_q       <= ST_SEND_ACK;
          end
        end
        ST_SEND_ACK: begin
          if (tx_ready) state_q <= err_q ? ST_WAIT_INIT : ST_RECV;
        end
        ST_RECV: begin
          if (data_take) state_q <= ST_PUMP;
        end
        ST_PUMP: begin
          if (pump_last) begin
            frames_left_q <= frames_left_q - 1'b1;
            if (frames_left_q == 16'd1) begin
              state_q    <= ST_HALT;
              done       <= 1'b1;
              start_addr <= BASE_ADDR;
            end else begin
              state_q <= ST_RECV;
            end
          end else if (!pump_busy) begin
            state_q <= ST_RECV;
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

endmodule

// File: rtl/can_boot_seq_chk.sv
module can_boot_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [63:0]       tx_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done
);

  // R7
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R7
  ack_blocks_rx_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !rx_ready);

  // R10
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 1'b1);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  done_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> wr_en);

  // R11
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !rx_ready && !tx_valid && !wr_en);

endmodule

bind can_boot_seq can_boot_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .wr_en(wr_en),
  .wr_addr(wr_addr), .done(done)
);

// File: tb/can_boot_seq_bench.sv
module can_boot_seq_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h1FFF_C000;
  localparam int          NVEC       = 9;

  // {id29, ide, dlc4, data64, exp_ack, exp_err}
  localparam logic [99:0] VEC [NVEC] = '{
    {29'h555, 1'b0, 4'd8, 64'h0234_0003_0123_5555, 1'b1, 1'b0}, // well formed
    {29'h554, 1'b0, 4'd8, 64'h0234_0003_0123_5555, 1'b0, 1'b0}, // wrong id
    {29'h555, 1'b1, 4'd8, 64'h0234_0003_0123_5555, 1'b0, 1'b0}, // extended flag
    {29'h555, 1'b0, 4'd7, 64'h0234_0003_0123_5555, 1'b0, 1'b0}, // short dlc
    {29'h555, 1'b0, 4'd8, 64'h0234_0003_0123_5554, 1'b0, 1'b0}, // bad sync
    {29'h555, 1'b0, 4'd8, 64'h0234_0000_0123_5555, 1'b1, 1'b1}, // zero count
    {29'h555, 1'b0, 4'd8, 64'h0234_0800_0123_5555, 1'b1, 1'b0}, // full window
    {29'h555, 1'b0, 4'd8, 64'h0234_0801_0123_5555, 1'b1, 1'b1}, // one over
    {29'h555, 1'b0, 4'd8, 64'h7777_0001_2ABC_5555, 1'b1, 1'b0}  // extended reply
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [28:0] rx_id = '0;
  logic        rx_ide = 1'b0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic [15:0] bit_timing = 16'h0000;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [28:0] tx_id;
  logic        tx_ide;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        wr_en;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic        done;
  logic [31:0] start_addr;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int nw = 0;
  int ndone = 0;
  int done_at = -1;
  logic [31:0] w_addr [64];
  logic [7:0]  w_data [64];
  int          w_cyc  [64];

  can_boot_seq u_can_boot_seq (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_id(rx_id), .rx_ide(rx_ide), .rx_dlc(rx_dlc), .rx_data(rx_data),
    .bit_timing(bit_timing), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_id(tx_id), .tx_ide(tx_ide), .tx_dlc(tx_dlc), .tx_data(tx_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
    .start_addr(start_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (wr_en) begin
      if (nw < 64) begin
        w_addr[nw] = wr_addr;
        w_data[nw] = wr_data;
        w_cyc[nw]  = cyc;
      end
      if (done) done_at = nw;
      nw++;
    end
    if (done) ndone++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rx_valid = 1'b0;
    tx_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    nw = 0;
    ndone = 0;
    done_at = -1;
  endtask

  task automatic send(input logic [28:0] id, input logic ide, input logic [3:0] dlc, input logic [63:0] d);
    logic rdy;
    @(negedge clk);
    rx_id = id; rx_ide = ide; rx_dlc = dlc; rx_data = d; rx_valid = 1'b1;
    do begin
      rdy = rx_ready;
      @(posedge clk);
      #1;
    end while (!rdy);
    rx_valid = 1'b0;
  endtask

  task automatic take_ack();
    @(negedge clk);
    tx_ready = 1'b1;
    @(posedge clk);
    #1;
    tx_ready = 1'b0;
  endtask

  function automatic logic [7:0] dl_byte(input int k);
    return 8'((k / 8) * 16 + (k % 8) + 8'h30);
  endfunction

  function automatic logic [63:0] dl_frame(input int f);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = dl_byte(f * 8 + b);
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk(rx_ready == 1'b1, "R1 rx_ready", 64'(rx_ready), 64'd1);
    chk(!tx_valid && !wr_en && !done, "R1 outputs idle", {tx_valid, wr_en, done}, 64'd0);
    chk(start_addr == 32'd0, "R1 start_addr", 64'(start_addr), 64'd0);

    // Vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      logic [28:0] vid;  logic vide;  logic [3:0] vdlc;  logic [63:0] vd;
      logic eack, eerr;  logic [63:0] exp_d;
      {vid, vide, vdlc, vd, eack, eerr} = VEC[i];
      do_reset();
      bit_timing = 16'h1C00 + 16'(i);
      send(vid, vide, vdlc, vd);
      bit_timing = 16'hFFFF;
      repeat (2) @(negedge clk);
      chk(tx_valid == eack, $sformatf("R2 vector %0d reply present", i), 64'(tx_valid), 64'(eack));
      if (!eack) begin
        chk(rx_ready == 1'b1, $sformatf("R2 vector %0d consumed", i), 64'(rx_ready), 64'd1);
      end else begin
        exp_d = {eerr ? 16'hEFBE : vd[63:48], eerr ? 16'hADDE : vd[47:32],
                 vd[31:16], 16'h1C00 + 16'(i)};
        chk(tx_id == {16'd0, vd[28:16]} && tx_ide == vd[29] && tx_dlc == 4'd8,
            $sformatf("R3 vector %0d reply id", i), {tx_ide, tx_dlc, tx_id}, {vd[29], 4'd8, 16'd0, vd[28:16]});
        chk(tx_data[31:0] == exp_d[31:0], $sformatf("R4 vector %0d reply low", i), tx_data, exp_d);
        chk(tx_data[63:32] == exp_d[63:32], $sformatf("R5 R6 vector %0d reply high", i), tx_data, exp_d);
      end
    end

    // R7 R8: held reply and error return
    do_reset();
    send(29'h555, 1'b0, 4'd8, 64'h0234_0000_0123_5555);
    repeat (5) @(negedge clk);
    chk(tx_valid && !rx_ready, "R7 reply held", {tx_valid, rx_ready}, 64'b10);
    chk(tx_data[63:32] == 32'hEFBE_ADDE, "R7 reply stable", tx_data, 64'hEFBE_ADDE_0000_0000);
    take_ack();
    @(negedge clk);
    chk(!tx_valid && rx_ready, "R8 back to waiting", {tx_valid, rx_ready}, 64'b01);
    send(29'h234, 1'b0, 4'd8, 64'h1111_1111_1111_1111);
    repeat (12) @(negedge clk);
    chk(nw == 0, "R8 no writes after error", 64'(nw), 64'd0);

    // R9 R10 R11 download of three frames with decoys
    send(29'h555, 1'b0, 4'd8, 64'h0234_0003_0123_5555);
    repeat (2) @(negedge clk);
    take_ack();
    send(29'h234, 1'b0, 4'd8, dl_frame(0));
    send(29'h235, 1'b0, 4'd8, 64'hDEAD_DEAD_DEAD_DEAD);
    send(29'h234, 1'b0, 4'd4, 64'hDEAD_DEAD_DEAD_DEAD);
    send(29'h234, 1'b1, 4'd8, 64'hDEAD_DEAD_DEAD_DEAD);
    repeat (2) @(negedge clk);
    chk(nw == 8, "R9 decoys ignored", 64'(nw), 64'd8);
    send(29'h234, 1'b0, 4'd8, dl_frame(1));
    #2;
    chk(rx_ready == 1'b0, "R10 back-pressure during write", 64'(rx_ready), 64'd0);
    send(29'h234, 1'b0, 4'd8, dl_frame(2));
    repeat (12) @(negedge clk);
    chk(nw == 24, "R9 write count", 64'(nw), 64'd24);
    for (int k = 0; k < 24 && k < nw; k++) begin
      chk(w_addr[k] == BASE + 32'(k) && w_data[k] == dl_byte(k),
          $sformatf("R10 byte %0d", k), {w_addr[k], 24'd0, w_data[k]}, {BASE + 32'(k), 24'd0, dl_byte(k)});
      if (k % 8 != 0)
        chk(w_cyc[k] == w_cyc[k-1] + 1, $sformatf("R10 byte %0d consecutive", k), 64'(w_cyc[k]), 64'(w_cyc[k-1] + 1));
    end
    chk(ndone == 1 && done_at == 23, "R11 done once with last byte", {32'(ndone), 32'(done_at)}, {32'd1, 32'd23});
    chk(start_addr == BASE, "R11 start_addr", 64'(start_addr), 64'(BASE));
    chk(rx_ready == 1'b0, "R11 rx_ready low after done", 64'(rx_ready), 64'd0);
    @(negedge clk);
    rx_id = 29'h234; rx_ide = 1'b0; rx_dlc = 4'd8; rx_valid = 1'b1;
    repeat (12) @(negedge clk);
    rx_valid = 1'b0;
    chk(nw == 24 && !done, "R11 quiet after done", 64'(nw), 64'd24);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule